// File: doc/BRIEF.md
# Dual-Mode Host Port Decoder

This block sits between a parallel microprocessor bus and the register and memory resources of a time-slot switch. A static mode pin chooses between two bus styles. With the pin low, the host drives a separate 8-bit address and a 16-bit data word. With the pin high, the host uses a shared address/data byte plus an upper data byte, and marks the address phase with a latch-enable pulse. In the multiplexed case the block works out which of two strobe conventions the host uses. It does this by looking at the data-strobe/read pin at the moment the latch enable rises.

Each completed access is decoded into one of three things: a strobe for one of four internal registers, a request into a channel page of the connection or data memory, or nothing for an unmapped address. The memory page is chosen by a memory-select bit and stream bits. Both live in the control register, which this block owns. Writes to read-only locations are dropped but still acknowledged. All pins are sampled on the block clock, and the transfer acknowledge follows a fixed latency.

Top module: `hp_port`

## Requirements
- R1: With `bus_mux_i` low, the address comes from `addr_i` and data is `{dhi_i, ad_i}`. An access is active while `cs_ni` and `ds_rd_i` are both low, and `rw_wr_i` high means read.
- R2: With `bus_mux_i` high, the address is taken from `ad_i` on a rising edge of `ale_i`. Write data is `{dhi_i, ad_i}` during the data phase, and `addr_i` is ignored.
- R3: In multiplexed mode, `ds_rd_i` low at the rising edge of `ale_i` selects style 1 (`tmode_o`=0). In style 1 the strobe `ds_rd_i` is active high and `rw_wr_i` high means read. `ds_rd_i` high at that edge selects style 2 (`tmode_o`=1). In style 2, `ds_rd_i` low is a read and `rw_wr_i` low is a write.
- R4: An address with bit 7 low and bits 6..0 below 4 hits a register. It gives one `reg_rd_o` or `reg_wr_o` pulse with `reg_idx_o` = bits 1..0. Index 0 is the mode register, 1 control, 2 frame alignment, 3 input offset.
- R5: An address with bit 7 high and bits 6..5 zero gives one `mem_req_o` pulse. `mem_chan_o` is bits 4..0, and `mem_sel_o` and `mem_stream_o` come from the control register. `mem_sel_o` 0 means connection memory and 1 means data memory.
- R6: A write to register index 1 loads the stream bits from data bits 3..0 and the memory-select bit from data bit 4. These values apply to the memory accesses that follow.
- R7: A write to register index 2, or a memory write while the memory-select bit is 1, produces no strobe and no request.
- R8: Any other address (bit 7 low with bits 6..0 of 4 or more, or bit 7 high with bits 6..5 non-zero) produces no strobe, but the access is still acknowledged.
- R9: `ack_o` rises after the third clock edge that samples chip select and strobe both active. It stays high until the first edge that samples them inactive, and falls right after that edge.
- R10: Each access produces at most one one-cycle strobe or request, in the cycle in which `ack_o` rises.
- R11: A latch-enable pulse during an active access does not redirect that access and does not change `tmode_o`.
- R12: After reset all outputs are low and the control register fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_mux_i | input | 1 | Bus style pin: 0 separate address, 1 multiplexed |
| cs_ni | input | 1 | Chip select, active low |
| ds_rd_i | input | 1 | Data strobe or read strobe |
| rw_wr_i | input | 1 | Read/write select or write strobe |
| ale_i | input | 1 | Address strobe / latch enable |
| addr_i | input | 8 | Separate address bus |
| ad_i | input | 8 | Shared address / low data byte |
| dhi_i | input | 8 | High data byte |
| ack_o | output | 1 | Transfer acknowledge |
| tmode_o | output | 1 | Detected multiplexed style (0 style 1, 1 style 2) |
| reg_wr_o | output | 1 | Register write pulse |
| reg_rd_o | output | 1 | Register read pulse |
| reg_idx_o | output | 2 | Register index |
| mem_req_o | output | 1 | Memory request pulse |
| mem_we_o | output | 1 | Memory request is a write |
| mem_sel_o | output | 1 | Memory select: 0 connection, 1 data |
| mem_stream_o | output | 4 | Stream page from the control register |
| mem_chan_o | output | 5 | Channel within the page |
| wdata_o | output | 16 | Write data of the last access |

## Verification
The critical overlap is a latch-enable rising edge that lands in the same cycle as the decode and strobe of an access still in progress. The new address latch and the access completion then compete for the same address path. The bench provokes this in both multiplexed styles. It raises `ale_i` with a different address on the shared bus, with the strobe level that would otherwise flip the detected style, one cycle before the acknowledge. It judges the case correct when the pulse carries the fields of the original address and `tmode_o` is unchanged after release.

// File: rtl/hp_port_pkg.sv
package hp_port_pkg;
  localparam int REG_IDX_W = 2;
  localparam int NUM_REGS  = 4;

  localparam logic [REG_IDX_W-1:0] REG_MODE  = 2'd0;
  localparam logic [REG_IDX_W-1:0] REG_CTRL  = 2'd1;
  localparam logic [REG_IDX_W-1:0] REG_ALIGN = 2'd2;
  localparam logic [REG_IDX_W-1:0] REG_OFFS  = 2'd3;

  typedef enum logic [1:0] {
    BUS_SPLIT = 2'd0,
    BUS_MUX_S1 = 2'd1,
    BUS_MUX_S2 = 2'd2
  } bus_style_e;
endpackage

// File: rtl/hp_in_stage.sv
module hp_in_stage
  import hp_port_pkg::*;
#(
  parameter int AW = 8,
  parameter int BW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            mux_i,
  input  logic            cs_ni,
  input  logic            ds_rd_i,
  input  logic            rw_wr_i,
  input  logic            ale_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [BW-1:0]   ad_i,
  input  logic [BW-1:0]   dhi_i,
  output logic            act_o,
  output logic            rd_o,
  output logic [AW-1:0]   addr_o,
  output logic [2*BW-1:0] wdata_o,
  output logic            tmode_o
);
  logic          mux_q, cs_q, ds_q, rw_q, ale_q, ale_d_q;
  logic [AW-1:0] addr_q, madr_q, madr_d;
  logic [BW-1:0] ad_q, dhi_q;
  logic          tm_q, tm_d;
  logic          ale_rise;
  bus_style_e    style;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mux_q   <= 1'b0;
      cs_q    <= 1'b1;
      ds_q    <= 1'b1;
      rw_q    <= 1'b1;
      ale_q   <= 1'b0;
      ale_d_q <= 1'b0;
      addr_q  <= '0;
      ad_q    <= '0;
      dhi_q   <= '0;
      madr_q  <= '0;
      tm_q    <= 1'b0;
    end else begin
      mux_q   <= mux_i;
      cs_q    <= cs_ni;
      ds_q    <= ds_rd_i;
      rw_q    <= rw_wr_i;
      ale_q   <= ale_i;
      ale_d_q <= ale_q;
      addr_q  <= addr_i;
      ad_q    <= ad_i;
      dhi_q   <= dhi_i;
      madr_q  <= madr_d;
      tm_q    <= tm_d;
    end
  end

  always_comb begin
    if (!mux_q)     style = BUS_SPLIT;
    else if (!tm_q) style = BUS_MUX_S1;
    else            style = BUS_MUX_S2;
  end

  always_comb begin
    act_o = 1'b0;
    rd_o  = 1'b1;
    unique case (style)
      BUS_SPLIT: begin
        act_o = !cs_q && !ds_q;
        rd_o  = rw_q;
      end
      BUS_MUX_S1: begin
        act_o = !cs_q && ds_q;
        rd_o  = rw_q;
      end
      default: begin
        act_o = !cs_q && (!ds_q || !rw_q);
        rd_o  = !ds_q;
      end
    endcase
  end

  assign ale_rise = ale_q && !ale_d_q;
  assign madr_d   = ale_rise ? AW'(ad_q) : madr_q;
  assign tm_d     = (ale_rise && !act_o) ? ds_q : tm_q;

  assign addr_o  = mux_q ? madr_q : addr_q;
  assign wdata_o = {dhi_q, ad_q};
  assign tmode_o = tm_q;
endmodule

// File: rtl/hp_ack_timer.sv
module hp_ack_timer #(
  parameter int LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic start_o,
  output logic fire_o,
  output logic ack_o
);
  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!act_i)                 cnt_d = '0;
    else if (cnt_q < CW'(LAT))  cnt_d = cnt_q + 1'b1;
    else                        cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign start_o = act_i && (cnt_q == '0);
  assign fire_o  = act_i && (cnt_q == CW'(LAT - 1));
  assign ack_o   = act_i && (cnt_q == CW'(LAT));
endmodule

// File: rtl/hp_decode.sv
module hp_decode
  import hp_port_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0]        addr_i,
  output logic                 reg_hit_o,
  output logic [REG_IDX_W-1:0] reg_idx_o,
  output logic                 mem_hit_o,
  output logic [AW-4:0]        chan_o
);
  assign reg_hit_o = !addr_i[AW-1] && (addr_i[AW-2:0] < (AW-1)'(NUM_REGS));
  assign reg_idx_o = addr_i[REG_IDX_W-1:0];
  assign mem_hit_o = addr_i[AW-1] && (addr_i[AW-2:AW-3] == 2'b00);
  assign chan_o    = addr_i[AW-4:0];
endmodule

// File: rtl/hp_port.sv
module hp_port
  import hp_port_pkg::*;
#(
  parameter int AW      = 8,
  parameter int BW      = 8,
  parameter int STW     = 4,
  parameter int ACK_LAT = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bus_mux_i,
  input  logic                 cs_ni,
  input  logic                 ds_rd_i,
  input  logic                 rw_wr_i,
  input  logic                 ale_i,
  input  logic [AW-1:0]        addr_i,
  input  logic [BW-1:0]        ad_i,
  input  logic [BW-1:0]        dhi_i,
  output logic                 ack_o,
  output logic                 tmode_o,
  output logic                 reg_wr_o,
  output logic                 reg_rd_o,
  output logic [REG_IDX_W-1:0] reg_idx_o,
  output logic                 mem_req_o,
  output logic                 mem_we_o,
  output logic                 mem_sel_o,
  output logic [STW-1:0]       mem_stream_o,
  output logic [AW-4:0]        mem_chan_o,
  output logic [2*BW-1:0]      wdata_o
);
  localparam int DW  = 2 * BW;
  localparam int CHW = AW - 3;

  logic [1:0]           rst_sync_q;
  logic                 rst_n;
  logic                 act, in_rd, start, fire;
  logic [AW-1:0]        in_addr, acc_addr_q, eff_addr;
  logic [DW-1:0]        in_wdata;
  logic                 acc_rd_q, eff_rd;
  logic                 reg_hit, mem_hit;
  logic [REG_IDX_W-1:0] dec_idx;
  logic [CHW-1:0]       dec_chan;
  logic                 reg_wr_d, reg_rd_d, mem_req_d, ctl_en;
  logic                 sel_q;
  logic [STW-1:0]       stream_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  hp_in_stage #(.AW(AW), .BW(BW)) u_in (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .mux_i   (bus_mux_i),
    .cs_ni   (cs_ni),
    .ds_rd_i (ds_rd_i),
    .rw_wr_i (rw_wr_i),
    .ale_i   (ale_i),
    .addr_i  (addr_i),
    .ad_i    (ad_i),
    .dhi_i   (dhi_i),
    .act_o   (act),
    .rd_o    (in_rd),
    .addr_o  (in_addr),
    .wdata_o (in_wdata),
    .tmode_o (tmode_o)
  );

  hp_ack_timer #(.LAT(ACK_LAT)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .act_i   (act),
    .start_o (start),
    .fire_o  (fire),
    .ack_o   (ack_o)
  );

  // access fields frozen at the first active cycle
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      acc_addr_q <= '0;
      acc_rd_q   <= 1'b1;
    end else if (start) begin
      acc_addr_q <= in_addr;
      acc_rd_q   <= in_rd;
    end
  end

  assign eff_addr = start ? in_addr : acc_addr_q;
  assign eff_rd   = start ? in_rd   : acc_rd_q;

  hp_decode #(.AW(AW)) u_dec (
    .addr_i    (eff_addr),
    .reg_hit_o (reg_hit),
    .reg_idx_o (dec_idx),
    .mem_hit_o (mem_hit),
    .chan_o    (dec_chan)
  );

  always_comb begin
    reg_rd_d  = fire && reg_hit && eff_rd;
    reg_wr_d  = fire && reg_hit && !eff_rd && (dec_idx != REG_ALIGN);
    mem_req_d = fire && mem_hit && (eff_rd || !sel_q);
    ctl_en    = reg_wr_d && (dec_idx == REG_CTRL);
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      reg_wr_o  <= 1'b0;
      reg_rd_o  <= 1'b0;
      mem_req_o <= 1'b0;
    end else begin
      reg_wr_o  <= reg_wr_d;
      reg_rd_o  <= reg_rd_d;
      mem_req_o <= mem_req_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      reg_idx_o    <= '0;
      mem_we_o     <= 1'b0;
      mem_sel_o    <= 1'b0;
      mem_stream_o <= '0;
      mem_chan_o   <= '0;
      wdata_o      <= '0;
    end else if (fire) begin
      reg_idx_o    <= dec_idx;
      mem_we_o     <= !eff_rd;
      mem_sel_o    <= sel_q;
      mem_stream_o <= stream_q;
      mem_chan_o   <= dec_chan;
      wdata_o      <= in_wdata;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= 1'b0;
      stream_q <= '0;
    end else if (ctl_en) begin
      sel_q    <= in_wdata[STW];
      stream_q <= in_wdata[STW-1:0];
    end
  end
endmodule

// File: rtl/hp_port_chk.sv
module hp_port_chk
  import hp_port_pkg::*;
(
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ack_o,
  input logic                 act,
  input logic                 reg_wr_o,
  input logic                 reg_rd_o,
  input logic                 mem_req_o,
  input logic                 mem_we_o,
  input logic                 mem_sel_o,
  input logic [REG_IDX_W-1:0] reg_idx_o
);
  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({reg_wr_o, reg_rd_o, mem_req_o})); // R10
  AST_STROBE_AT_ACK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_o || reg_rd_o || mem_req_o) |-> $rose(ack_o)); // R10
  AST_ACK_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(act, 2)); // R9
  AST_ACK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> (ack_o || !act)); // R9
  AST_NO_ALIGN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |-> (reg_idx_o != REG_ALIGN)); // R7
  AST_NO_DATA_MEM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> !mem_sel_o); // R7
endmodule

bind hp_port hp_port_chk chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ack_o     (ack_o),
  .act       (act),
  .reg_wr_o  (reg_wr_o),
  .reg_rd_o  (reg_rd_o),
  .mem_req_o (mem_req_o),
  .mem_we_o  (mem_we_o),
  .mem_sel_o (mem_sel_o),
  .reg_idx_o (reg_idx_o)
);

// File: tb/hp_port_tb_top.sv
module hp_port_tb_top;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, mux, cs_n, ds_rd, rw_wr, ale;
  logic [7:0] addr, ad, dhi;
  logic ack, tmode, reg_wr, reg_rd, mem_req, mem_we, mem_sel;
  logic [1:0] reg_idx;
  logic [3:0] mem_stream;
  logic [4:0] mem_chan;
  logic [15:0] wdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  logic m_sel;
  logic [3:0] m_stream;

  hp_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_mux_i(mux), .cs_ni(cs_n), .ds_rd_i(ds_rd),
    .rw_wr_i(rw_wr), .ale_i(ale), .addr_i(addr), .ad_i(ad), .dhi_i(dhi),
    .ack_o(ack), .tmode_o(tmode), .reg_wr_o(reg_wr), .reg_rd_o(reg_rd),
    .reg_idx_o(reg_idx), .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_sel_o(mem_sel),
    .mem_stream_o(mem_stream), .mem_chan_o(mem_chan), .wdata_o(wdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bm: 0 separate address, 1 multiplexed style 1, 2 multiplexed style 2
  task automatic access(input int bm, input logic [7:0] a, input bit wr,
                        input logic [15:0] d, input bit ovl);
    bit er, ew, em;
    string rq;
    er = !a[7] && (a[6:2] == 0) && !wr;
    ew = !a[7] && (a[6:2] == 0) && wr && (a[1:0] != 2'd2);
    em = a[7] && (a[6:5] == 0) && (!wr || !m_sel);
    if (a[7]) rq = (a[6:5] != 0) ? "R8" : ((wr && m_sel) ? "R7" : "R5");
    else      rq = (a[6:2] != 0) ? "R8" : ((wr && a[1:0] == 2'd2) ? "R7" : "R4");
    mux = (bm != 0); ds_rd = (bm != 1); rw_wr = 1'b1; cs_n = 1'b1; ale = 1'b0;
    @(negedge clk);
    if (bm == 0) begin
      addr = a; ad = d[7:0]; dhi = d[15:8];
    end else begin
      ad = a; addr = ~a; ale = 1'b1;
      @(negedge clk);
      ale = 1'b0; ad = d[7:0]; dhi = d[15:8];
      @(negedge clk);
      chk("R3 timing style", 32'(tmode), 32'(bm == 2));
    end
    cs_n = 1'b0;
    if (bm == 0)      begin ds_rd = 1'b0; rw_wr = !wr; end
    else if (bm == 1) begin ds_rd = 1'b1; rw_wr = !wr; end
    else if (wr)      rw_wr = 1'b0;
    else              ds_rd = 1'b0;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R9 ack early", 32'({ack, reg_wr, reg_rd, mem_req}), 32'h0);
      if (i == 1 && ovl) begin ale = 1'b1; ad = a ^ 8'h01; end
    end
    @(negedge clk);
    ale = 1'b0;
    chk("R9 ack rise", 32'(ack), 32'h1);
    chk({rq, " strobe"}, 32'({reg_wr, reg_rd, mem_req}), 32'({ew, er, em}));
    if (ew || er) chk("R4 reg index", 32'(reg_idx), 32'(a[1:0]));
    if (em) chk(ovl ? "R11 mem fields" : "R5 mem fields",
                32'({mem_we, mem_sel, mem_stream, mem_chan}),
                32'({wr, m_sel, m_stream, a[4:0]}));
    if (wr && (ew || em)) chk(bm == 0 ? "R1 write data" : "R2 write data", 32'(wdata), 32'(d));
    @(negedge clk);
    chk("R10 single pulse", 32'({ack, reg_wr, reg_rd, mem_req}), 32'h8);
    cs_n = 1'b1; ds_rd = (bm != 1); rw_wr = 1'b1;
    @(negedge clk);
    chk("R9 ack release", 32'(ack), 32'h0);
    if (ovl) chk("R11 style kept", 32'(tmode), 32'(bm == 2));
    if (ew && a[1:0] == 2'd1) begin
      m_stream = d[3:0];
      m_sel    = d[4];
    end
  endtask

  localparam logic [7:0] ADDRS [12] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h7F,
                                        8'h80, 8'h95, 8'h9F, 8'hA0, 8'hC1, 8'hE7};

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mux = 1'b0; cs_n = 1'b1; ds_rd = 1'b1; rw_wr = 1'b1; ale = 1'b0;
    addr = '0; ad = '0; dhi = '0; m_sel = 1'b0; m_stream = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12 reset outputs",
        32'({ack, tmode, reg_wr, reg_rd, reg_idx, mem_req, mem_we, mem_sel, mem_stream, mem_chan}), 32'h0);
    chk("R12 reset wdata", 32'(wdata), 32'h0);
    access(0, 8'h83, 1'b0, 16'h0, 1'b0); // R12 control fields cleared
    for (int bm = 0; bm < 3; bm++)
      foreach (ADDRS[k])
        for (int wr = 0; wr < 2; wr++)
          access(bm, ADDRS[k], wr[0], {ADDRS[k] ^ 8'h5A, 8'(bm * 37 + wr * 11 + k)}, 1'b0);
    for (int s = 0; s < 32; s++) begin // R6 stream and select sweep
      access(s % 3, 8'h01, 1'b1, {8'hC3, 8'(s)}, 1'b0);
      access((s + 1) % 3, 8'h80 | 8'(s), 1'b1, {8'(s), 8'hA5}, 1'b0);
      access((s + 2) % 3, 8'h9F ^ 8'(s), 1'b0, 16'h0, 1'b0);
    end
    for (int bm = 1; bm < 3; bm++) begin // R11 latch-enable during access
      access(bm, 8'h03, 1'b0, 16'h0, 1'b1);
      access(bm, 8'h9E, 1'b0, 16'h0, 1'b1);
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule